// File: doc/BRIEF.md
# Split Source Operand Selector

This block builds the 16-bit source bus that feeds a small processor's datapath. The two bytes of the bus are chosen by two separate lanes. The lower lane picks one of sixteen byte-wide sources with a 4-bit code. Those sources include the register bytes, the external data byte, a decimal-adjust value, the interrupt mask and the interrupt vector. The upper lane picks one of eight register bytes through one-hot enables. When none of those enables is active, the upper lane produces zero, or a sign-extension fill taken from the lower lane.

Each lane can invert its byte (one's complement) after selection. The sign-extension fill comes from the most significant bit of the lower byte as it was selected, before any inversion. The upper lane can also carry the low temp byte, so that an I/O port address appears on both halves of the bus at once. The block has no clock or state: the sequencer drives the select and control bits, and the bus settles within the same cycle.

Top module: `opsel_src_bus`

## Requirements
- R1: `lo_sel` picks the lower byte when `lo_inv`=0: 0 external data, 1 A, 2 flags, 3 B, 4 C, 5 D, 6 E, 7 H, 8 L, 9 temp[7:0], 10 SP[7:0], 11 PC[7:0], 12 decimal-adjust, 13 interrupt mask, 14 interrupt vector.
- R2: `lo_sel`=15 gives a lower byte of 0x00, or 0xFF when `lo_inv`=1.
- R3: `lo_inv`=1 gives the bitwise inverse of the byte that `lo_sel` selects.
- R4: The bits of `hi_en` select the upper byte when `hi_inv`=0: bit0 A, bit1 B, bit2 D, bit3 H, bit4 temp[7:0], bit5 temp[15:8], bit6 SP[15:8], bit7 PC[15:8].
- R5: With `hi_en`=0 and `sext_en`=0, the upper byte is 0x00, or 0xFF when `hi_inv`=1.
- R6: With `hi_en`=0 and `sext_en`=1, each upper bit equals bit 7 of the lower byte taken before `lo_inv` is applied.
- R7: `hi_inv`=1 inverts the upper byte after selection and sign extension.
- R8: With `hi_en`=0x10 and `lo_sel`=9, and no inversion, both bytes of the bus equal temp[7:0].
- R9: Legal controls have at most one bit of `hi_en` set, and `sext_en` set only when `hi_en`=0.
- R10: The bus is combinational: a change on any input reaches `src_bus` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_data | input | 8 | External address/data byte |
| acc | input | 8 | Accumulator |
| flags | input | 8 | Flag byte |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_h | input | 8 | Register H |
| reg_l | input | 8 | Register L |
| tmp_word | input | 16 | Temp register |
| sp_word | input | 16 | Stack pointer |
| pc_word | input | 16 | Program counter |
| dec_adj | input | 8 | Decimal-adjust value |
| irq_mask | input | 8 | Interrupt mask byte |
| irq_vec | input | 8 | Interrupt vector byte |
| lo_sel | input | 4 | Lower-lane select code |
| lo_inv | input | 1 | Invert lower byte |
| hi_en | input | 8 | One-hot upper-lane enables |
| sext_en | input | 1 | Sign-extend enable |
| hi_inv | input | 1 | Invert upper byte |
| src_bus | output | 16 | Source bus |

## Verification
On every evaluation, the assertions check the legality of the upper controls and the sign-extension fill. They also check the zero and all-ones defaults of an idle upper lane, plain and inverted pass-through on the lower lane, and the duplication of the I/O address. Only the bench scenarios can show the whole sixteen-code lower mapping and each upper enable position. They also show that the fill comes from the bit before inversion, when the lower lane is inverted at the same time. Finally, they show that the output follows an input change without any clock edge.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
   localparam int unsigned LANE_W  = 8;
   localparam int unsigned LO_SELW = 4;
   localparam int unsigned LO_NSRC = 1 << LO_SELW;
   localparam int unsigned HI_NSRC = 8;

   typedef enum logic [LO_SELW-1:0] {
      LO_EXT   = 4'd0,
      LO_ACC   = 4'd1,
      LO_FLG   = 4'd2,
      LO_B     = 4'd3,
      LO_C     = 4'd4,
      LO_D     = 4'd5,
      LO_E     = 4'd6,
      LO_H     = 4'd7,
      LO_L     = 4'd8,
      LO_TMPL  = 4'd9,
      LO_SPL   = 4'd10,
      LO_PCL   = 4'd11,
      LO_DADJ  = 4'd12,
      LO_IMSK  = 4'd13,
      LO_IVEC  = 4'd14,
      LO_NONE  = 4'd15
   } lo_code_e;

   localparam int unsigned HI_ACC  = 0;
   localparam int unsigned HI_B    = 1;
   localparam int unsigned HI_D    = 2;
   localparam int unsigned HI_H    = 3;
   localparam int unsigned HI_TMPL = 4;
   localparam int unsigned HI_TMPH = 5;
   localparam int unsigned HI_SPH  = 6;
   localparam int unsigned HI_PCH  = 7;
endpackage

// File: rtl/opsel_lane_inv.sv
module opsel_lane_inv #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] din,
   input  logic         inv,
   output logic [W-1:0] dout
);
   logic [W-1:0] inv_rep;

   generate
      if (W < 1) begin : g_bad_w
         $error("opsel_lane_inv: W must be at least 1");
      end
   endgenerate

   assign inv_rep = {W{inv}};
   assign dout    = din ^ inv_rep;
endmodule

// File: rtl/opsel_lane_lo.sv
module opsel_lane_lo #(
   parameter int unsigned W      = 8,
   parameter int unsigned SELW   = 4,
   parameter bit          ANDOR  = 1'b1,
   localparam int unsigned NSRC  = 1 << SELW
) (
   input  logic [NSRC-1:0][W-1:0] srcs,
   input  logic [SELW-1:0]        sel,
   output logic [W-1:0]           picked
);
   generate
      if (SELW < 1 || SELW > 6) begin : g_bad_sel
         $error("opsel_lane_lo: SELW out of range");
      end

      if (ANDOR) begin : g_andor
         logic [NSRC-1:0]         dec;
         logic [NSRC-1:0][W-1:0]  gated;
         for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign dec[i]   = (sel == SELW'(i));
            assign gated[i] = srcs[i] & {W{dec[i]}};
         end
         always_comb begin
            picked = '0;
            for (int k = 0; k < NSRC; k++) picked = picked | gated[k];
         end
      end else begin : g_index
         assign picked = srcs[sel];
      end
   endgenerate
endmodule

// File: rtl/opsel_lane_hi.sv
module opsel_lane_hi #(
   parameter int unsigned W    = 8,
   parameter int unsigned NSRC = 8
) (
   input  logic [NSRC-1:0][W-1:0] srcs,
   input  logic [NSRC-1:0]        en,
   input  logic                   sext_en,
   input  logic                   sign_bit,
   output logic [W-1:0]           merged
);
   logic [NSRC-1:0][W-1:0] gated;
   logic [W-1:0]           or_tree;
   logic [W-1:0]           fill;

   generate
      if (NSRC < 1) begin : g_bad_n
         $error("opsel_lane_hi: NSRC must be at least 1");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign gated[i] = srcs[i] & {W{en[i]}};
      end
   endgenerate

   always_comb begin
      or_tree = '0;
      for (int k = 0; k < NSRC; k++) or_tree = or_tree | gated[k];
   end

   assign fill   = {W{sext_en & sign_bit}};
   assign merged = or_tree ^ fill;

   always_comb begin
      if (en == '0 && sext_en)
         assert_sext_fill_R6: assert (merged == {W{sign_bit}})
            else $error("sign fill mismatch");
      if (en == '0 && !sext_en)
         assert_idle_zero_R5: assert (merged == '0)
            else $error("idle upper lane not zero");
   end
endmodule

// File: rtl/opsel_src_bus.sv
module opsel_src_bus
   import opsel_pkg::*;
#(
   parameter int unsigned W     = LANE_W,
   parameter bit          ANDOR = 1'b1,
   localparam int unsigned BUSW = 2 * W
) (
   input  logic [W-1:0]       ext_data,
   input  logic [W-1:0]       acc,
   input  logic [W-1:0]       flags,
   input  logic [W-1:0]       reg_b,
   input  logic [W-1:0]       reg_c,
   input  logic [W-1:0]       reg_d,
   input  logic [W-1:0]       reg_e,
   input  logic [W-1:0]       reg_h,
   input  logic [W-1:0]       reg_l,
   input  logic [BUSW-1:0]    tmp_word,
   input  logic [BUSW-1:0]    sp_word,
   input  logic [BUSW-1:0]    pc_word,
   input  logic [W-1:0]       dec_adj,
   input  logic [W-1:0]       irq_mask,
   input  logic [W-1:0]       irq_vec,
   input  logic [LO_SELW-1:0] lo_sel,
   input  logic               lo_inv,
   input  logic [HI_NSRC-1:0] hi_en,
   input  logic               sext_en,
   input  logic               hi_inv,
   output logic [BUSW-1:0]    src_bus
);
   logic [LO_NSRC-1:0][W-1:0] lo_srcs;
   logic [HI_NSRC-1:0][W-1:0] hi_srcs;
   logic [W-1:0] lo_raw, hi_raw, lo_out, hi_out;

   generate
      if (W < 2) begin : g_bad_w
         $error("opsel_src_bus: W must be at least 2");
      end
   endgenerate

   always_comb begin
      lo_srcs          = '0;
      lo_srcs[LO_EXT]  = ext_data;
      lo_srcs[LO_ACC]  = acc;
      lo_srcs[LO_FLG]  = flags;
      lo_srcs[LO_B]    = reg_b;
      lo_srcs[LO_C]    = reg_c;
      lo_srcs[LO_D]    = reg_d;
      lo_srcs[LO_E]    = reg_e;
      lo_srcs[LO_H]    = reg_h;
      lo_srcs[LO_L]    = reg_l;
      lo_srcs[LO_TMPL] = tmp_word[W-1:0];
      lo_srcs[LO_SPL]  = sp_word[W-1:0];
      lo_srcs[LO_PCL]  = pc_word[W-1:0];
      lo_srcs[LO_DADJ] = dec_adj;
      lo_srcs[LO_IMSK] = irq_mask;
      lo_srcs[LO_IVEC] = irq_vec;
   end

   always_comb begin
      hi_srcs          = '0;
      hi_srcs[HI_ACC]  = acc;
      hi_srcs[HI_B]    = reg_b;
      hi_srcs[HI_D]    = reg_d;
      hi_srcs[HI_H]    = reg_h;
      hi_srcs[HI_TMPL] = tmp_word[W-1:0];
      hi_srcs[HI_TMPH] = tmp_word[BUSW-1:W];
      hi_srcs[HI_SPH]  = sp_word[BUSW-1:W];
      hi_srcs[HI_PCH]  = pc_word[BUSW-1:W];
   end

   opsel_lane_lo #(.W(W), .SELW(LO_SELW), .ANDOR(ANDOR)) u_lo (
      .srcs(lo_srcs), .sel(lo_sel), .picked(lo_raw)
   );

   opsel_lane_hi #(.W(W), .NSRC(HI_NSRC)) u_hi (
      .srcs(hi_srcs), .en(hi_en), .sext_en(sext_en),
      .sign_bit(lo_raw[W-1]), .merged(hi_raw)
   );

   opsel_lane_inv #(.W(W)) u_lo_inv (.din(lo_raw), .inv(lo_inv), .dout(lo_out));
   opsel_lane_inv #(.W(W)) u_hi_inv (.din(hi_raw), .inv(hi_inv), .dout(hi_out));

   assign src_bus = {hi_out, lo_out};

   always_comb begin
      assert_ctrl_legal_R9: assert ($onehot0(hi_en) && !(sext_en && (hi_en != '0)))
         else $error("illegal upper controls");
      if (!lo_inv && lo_sel == LO_ACC)
         assert_lo_pass_R1: assert (src_bus[W-1:0] == acc)
            else $error("lower pass-through mismatch");
      if (lo_inv && lo_sel == LO_B)
         assert_lo_inv_R3: assert (src_bus[W-1:0] == ~reg_b)
            else $error("lower inversion mismatch");
      if (hi_en == '0 && !sext_en)
         assert_hi_idle_R7: assert (src_bus[BUSW-1:W] == {W{hi_inv}})
            else $error("idle upper default mismatch");
      if (hi_en == HI_NSRC'(1 << HI_TMPL) && !hi_inv && !lo_inv && lo_sel == LO_TMPL)
         assert_io_dup_R8: assert (src_bus[BUSW-1:W] == src_bus[W-1:0])
            else $error("port address not duplicated");
   end
endmodule

// File: tb/sim_opsel_src_bus.sv
module sim_opsel_src_bus;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0]  ext_data, acc, flags, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l;
   logic [15:0] tmp_word, sp_word, pc_word;
   logic [7:0]  dec_adj, irq_mask, irq_vec;
   logic [3:0]  lo_sel;
   logic        lo_inv, sext_en, hi_inv;
   logic [7:0]  hi_en;
   logic [15:0] src_bus;

   int n_chk = 0;
   int n_bad = 0;

   opsel_src_bus u0 (.*);

   function automatic logic [7:0] exp_lo(input logic [3:0] c);
      case (c)
         4'd0: return ext_data;  4'd1: return acc;       4'd2: return flags;
         4'd3: return reg_b;     4'd4: return reg_c;     4'd5: return reg_d;
         4'd6: return reg_e;     4'd7: return reg_h;     4'd8: return reg_l;
         4'd9: return tmp_word[7:0];  4'd10: return sp_word[7:0];
         4'd11: return pc_word[7:0];  4'd12: return dec_adj;
         4'd13: return irq_mask; 4'd14: return irq_vec;  default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_hi(input int b);
      case (b)
         0: return acc; 1: return reg_b; 2: return reg_d; 3: return reg_h;
         4: return tmp_word[7:0]; 5: return tmp_word[15:8];
         6: return sp_word[15:8]; default: return pc_word[15:8];
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle; @(negedge clk); endtask

   task automatic load_pattern(input logic [7:0] s);
      ext_data = s ^ 8'h11; acc = s ^ 8'h22; flags = s ^ 8'h33; reg_b = s ^ 8'h44;
      reg_c = s ^ 8'h55; reg_d = s ^ 8'h66; reg_e = s ^ 8'h77; reg_h = s ^ 8'h88;
      reg_l = s ^ 8'h99; tmp_word = {s ^ 8'hA1, s ^ 8'hAA}; sp_word = {s ^ 8'hB1, s ^ 8'hBB};
      pc_word = {s ^ 8'hC1, s ^ 8'hCC}; dec_adj = s ^ 8'hDD; irq_mask = s ^ 8'hEE;
      irq_vec = s ^ 8'hF0;
   endtask

   task automatic t_idle;   // R5: idle upper lane, R2 code 15
      lo_sel = 4'd15; lo_inv = 0; hi_en = 0; sext_en = 0; hi_inv = 0; settle();
      check("R5/R2 idle", src_bus, 16'h0000);
      lo_inv = 1; hi_inv = 1; settle();
      check("R5/R2 idle inverted", src_bus, 16'hFFFF);
   endtask

   task automatic t_lo_map(input logic [7:0] s);   // R1, R3
      load_pattern(s); hi_en = 0; sext_en = 0; hi_inv = 0;
      for (int c = 0; c < 16; c++) begin
         lo_sel = 4'(c); lo_inv = 0; settle();
         check("R1 lower map", src_bus, {8'h00, exp_lo(4'(c))});
         lo_inv = 1; settle();
         check("R3 lower inverted", src_bus, {8'h00, ~exp_lo(4'(c))});
      end
   endtask

   task automatic t_hi_map(input logic [7:0] s);   // R4, R7
      load_pattern(s); lo_sel = 4'd15; lo_inv = 0; sext_en = 0;
      for (int b = 0; b < 8; b++) begin
         hi_en = 8'(1 << b); hi_inv = 0; settle();
         check("R4 upper map", src_bus, {exp_hi(b), 8'h00});
         hi_inv = 1; settle();
         check("R7 upper inverted", src_bus, {~exp_hi(b), 8'h00});
      end
   endtask

   task automatic t_sext;   // R6, R7
      load_pattern(8'h00); hi_en = 0; sext_en = 1; hi_inv = 0;
      reg_c = 8'h85; lo_sel = 4'd4; lo_inv = 0; settle();
      check("R6 sign fill negative", src_bus, 16'hFF85);
      lo_inv = 1; settle();
      check("R6 fill uses pre-inversion bit", src_bus, 16'hFF7A);
      reg_c = 8'h3C; lo_inv = 0; settle();
      check("R6 sign fill positive", src_bus, 16'h003C);
      lo_inv = 1; settle();
      check("R6 fill positive, lower inverted", src_bus, 16'h00C3);
      hi_inv = 1; settle();
      check("R7 inversion after fill", src_bus, 16'hFFC3);
      sext_en = 0; hi_inv = 0; settle();
   endtask

   task automatic t_io_dup;   // R8
      load_pattern(8'h00); tmp_word = 16'h5A3E;
      lo_sel = 4'd9; lo_inv = 0; hi_en = 8'h10; sext_en = 0; hi_inv = 0; settle();
      check("R8 port address on both bytes", src_bus, 16'h3E3E);
   endtask

   task automatic t_comb;   // R10: no clock edge between change and sample
      load_pattern(8'h00); lo_sel = 4'd1; lo_inv = 0; hi_en = 8'h02; sext_en = 0; hi_inv = 0;
      settle();
      acc = 8'h9B; reg_b = 8'h47; #1;
      check("R10 combinational follow", src_bus, 16'h479B);
   endtask

   initial begin
      load_pattern(8'h00);
      lo_sel = 4'd15; lo_inv = 0; hi_en = 0; sext_en = 0; hi_inv = 0;
      t_idle();
      t_lo_map(8'h00);
      t_lo_map(8'hC3);
      t_hi_map(8'h00);
      t_hi_map(8'h5F);
      t_sext();
      t_io_dup();
      t_comb();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule